// File: doc/BRIEF.md
# Floppy Interface Soft-Switch Decoder

This block turns single-address accesses into the control state of a two-drive floppy disk interface. Eight one-bit soft switches are held inside it. The upper three bits of a 4-bit access address pick one switch, and the lowest bit gives that switch its new value. A strobe access therefore needs no data bus: the address alone both selects a switch and sets or clears it.

The switches feed three functions. Three phase lines and a head-side input form a small command code, and that code is acted on only when the strobe switch goes from set to cleared. The result is a one-cycle pulse for step-direction, step, motor-on or eject. The motor-enable switch drives a motor flag. When the flag is switched off, the switch-off can be held back for a programmable number of clock cycles, one second's worth by default. The drive-select switch chooses which of the two drives is active, and only the active drive sees the motor flag.

Any side effect happens only when an access really changes the switch it addresses. Writing a switch with the value it already holds leaves everything as it was.

Top module: `fdc_switch_decoder`

## Requirements
- R1: An access with `acc_valid` high at a clock edge writes `acc_addr[0]` into switch number `acc_addr[3:1]` of `switch_state`. The switch numbers are: 0 phase0, 1 phase1, 2 phase2, 3 strobe, 4 motor enable, 5 drive select, 6 and 7 mode. Reset clears all switches, all pulses, the motor flag and `drive_motor`, and selects drive 0.
- R2: No switch changes in a cycle without `acc_valid`, whatever `acc_addr` holds.
- R3: An access that writes a switch with its current value has no side effect. Clearing an already clear strobe gives no command, and clearing an already clear motor enable during a countdown does not restart the countdown.
- R4: When strobe falls (access to address 6 while strobe is set) and {phase1, phase0, side_sel} = 3'b000, `cmd_dir_pulse` fires and `cmd_dir_value` equals phase2.
- R5: On a strobe fall, the code {phase1, phase0, side_sel} gives 3'b010 a step pulse, 3'b100 a motor-on pulse and 3'b110 an eject pulse. Every other code gives no pulse.
- R6: Command pulses last exactly one cycle, appear in the cycle after the access edge, and at most one is high at a time.
- R7: Setting motor enable (address 9 while it is clear) raises the motor output of the active drive from the next cycle.
- R8: Clearing motor enable while `delay_bypass` is 0 keeps the motor on for exactly CLOCK_HZ edges counted from the access edge, then turns it off.
- R9: Clearing motor enable while `delay_bypass` is 1 turns the motor off from the next cycle.
- R10: Setting motor enable again during a pending switch-off cancels that switch-off.
- R11: `active_drive` equals the drive-select switch (address 10 gives drive 0, address 11 gives drive 1). Only the active drive's `drive_motor` bit follows the motor flag, and the other bit is 0.
- R12: Setting the strobe switch (its rising edge) never produces a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one access per high cycle |
| acc_addr | input | 4 | Access address: [3:1] switch number, [0] new value |
| side_sel | input | 1 | Head-side select, used in the strobe command code |
| delay_bypass | input | 1 | 1: motor stops at once; 0: delayed stop |
| switch_state | output | 8 | Current value of the eight switches |
| cmd_dir_pulse | output | 1 | One-cycle set-step-direction command |
| cmd_dir_value | output | 1 | Direction carried with `cmd_dir_pulse` |
| cmd_step_pulse | output | 1 | One-cycle step command |
| cmd_motor_on_pulse | output | 1 | One-cycle motor-on command |
| cmd_eject_pulse | output | 1 | One-cycle eject command |
| drive_motor | output | 2 | Motor-on line per drive |
| active_drive | output | 1 | Index of the selected drive |

## Verification
On every cycle the assertions check four things: idle cycles leave the switches alone, command pulses stay mutually exclusive and follow only a strobe fall, at most one drive motor is on and only the active one, and an enable-set or bypassed enable-clear reaches the motor outputs in the next cycle. Some behaviour can only be shown by the bench's scenarios. These are the exact length of the delayed switch-off, its cancellation, the fact that a redundant clear does not reload it, the mapping of each command code, and the movement of the motor to the other drive when the selection changes.

// File: rtl/fdc_sw_pkg.sv
package fdc_sw_pkg;
    localparam int NUM_SW     = 8;
    localparam int SW_IDX_W   = $clog2(NUM_SW);
    localparam int NUM_DRIVES = 2;

    // Switch numbers: the access address [3:1] selects these.
    typedef enum logic [SW_IDX_W-1:0] {
        SW_PH0     = 3'd0,
        SW_PH1     = 3'd1,
        SW_PH2     = 3'd2,
        SW_STROBE  = 3'd3,
        SW_MOTOR   = 3'd4,
        SW_DSEL    = 3'd5,
        SW_MODE_LO = 3'd6,
        SW_MODE_HI = 3'd7
    } sw_idx_e;

    // Command code {phase1, phase0, side}.
    typedef enum logic [2:0] {
        CODE_DIR   = 3'b000,
        CODE_STEP  = 3'b010,
        CODE_MOTOR = 3'b100,
        CODE_EJECT = 3'b110
    } cmd_code_e;

    typedef struct packed {
        logic dir;
        logic dir_val;
        logic step;
        logic motor_on;
        logic eject;
    } cmd_t;
endpackage

// File: rtl/fdc_switch_bank.sv
module fdc_switch_bank
    import fdc_sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [3:0]        acc_addr,
    output logic [NUM_SW-1:0] sw_q,
    output logic [NUM_SW-1:0] evt_set,
    output logic [NUM_SW-1:0] evt_clr
);
    typedef struct packed {
        logic [NUM_SW-1:0] sw;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NUM_SW-1:0] mask;

    always_comb begin
        st_d = st_q;
        mask = NUM_SW'(1) << acc_addr[3:1];
        if (acc_valid) begin
            if (acc_addr[0]) st_d.sw = st_q.sw | mask;
            else             st_d.sw = st_q.sw & ~mask;
        end
        // Only a real change of a switch counts as an event.
        evt_set = st_d.sw & ~st_q.sw;
        evt_clr = st_q.sw & ~st_d.sw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_q = st_q.sw;
endmodule

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
    import fdc_sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_fall,
    input  logic ph0,
    input  logic ph1,
    input  logic ph2,
    input  logic side_sel,
    output cmd_t cmd_q
);
    cmd_t      cmd_d;
    logic [2:0] code;

    always_comb begin
        cmd_d = '0;
        code  = {ph1, ph0, side_sel};
        if (strobe_fall) begin
            unique case (code)
                CODE_DIR: begin
                    cmd_d.dir     = 1'b1;
                    cmd_d.dir_val = ph2;
                end
                CODE_STEP:  cmd_d.step     = 1'b1;
                CODE_MOTOR: cmd_d.motor_on = 1'b1;
                CODE_EJECT: cmd_d.eject    = 1'b1;
                default:    cmd_d          = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end
endmodule

// File: rtl/fdc_motor_ctrl.sv
module fdc_motor_ctrl
    import fdc_sw_pkg::*;
#(
    parameter int CLOCK_HZ = 16_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_rise,
    input  logic                  en_fall,
    input  logic                  delay_bypass,
    input  logic                  active_drive,
    output logic [NUM_DRIVES-1:0] drive_motor
);
    localparam int CNT_W = $clog2(CLOCK_HZ + 1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } motor_st_t;

    motor_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_rise) begin
            st_d.flag = 1'b1;
            st_d.cnt  = '0;
        end else if (en_fall) begin
            if (delay_bypass) begin
                st_d.flag = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = CNT_W'(CLOCK_HZ);
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
        assign drive_motor[g] = st_q.flag && (active_drive == 1'(g));
    end
endmodule

// File: rtl/fdc_switch_decoder.sv
module fdc_switch_decoder
    import fdc_sw_pkg::*;
#(
    parameter int CLOCK_HZ = 16_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic [3:0] acc_addr,
    input  logic       side_sel,
    input  logic       delay_bypass,
    output logic [7:0] switch_state,
    output logic       cmd_dir_pulse,
    output logic       cmd_dir_value,
    output logic       cmd_step_pulse,
    output logic       cmd_motor_on_pulse,
    output logic       cmd_eject_pulse,
    output logic [1:0] drive_motor,
    output logic       active_drive
);
    logic [NUM_SW-1:0] sw_q, evt_set, evt_clr;
    cmd_t              cmd_q;

    fdc_switch_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_addr (acc_addr),
        .sw_q     (sw_q),
        .evt_set  (evt_set),
        .evt_clr  (evt_clr)
    );

    fdc_cmd_decode u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_fall(evt_clr[SW_STROBE]),
        .ph0        (sw_q[SW_PH0]),
        .ph1        (sw_q[SW_PH1]),
        .ph2        (sw_q[SW_PH2]),
        .side_sel   (side_sel),
        .cmd_q      (cmd_q)
    );

    fdc_motor_ctrl #(.CLOCK_HZ(CLOCK_HZ)) u_motor (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_rise     (evt_set[SW_MOTOR]),
        .en_fall     (evt_clr[SW_MOTOR]),
        .delay_bypass(delay_bypass),
        .active_drive(sw_q[SW_DSEL]),
        .drive_motor (drive_motor)
    );

    assign switch_state       = sw_q;
    assign active_drive       = sw_q[SW_DSEL];
    assign cmd_dir_pulse      = cmd_q.dir;
    assign cmd_dir_value      = cmd_q.dir_val;
    assign cmd_step_pulse     = cmd_q.step;
    assign cmd_motor_on_pulse = cmd_q.motor_on;
    assign cmd_eject_pulse    = cmd_q.eject;
endmodule

// File: rtl/fdc_switch_decoder_chk.sv
module fdc_switch_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [3:0] acc_addr,
    input logic       delay_bypass,
    input logic [7:0] switch_state,
    input logic       cmd_dir_pulse,
    input logic       cmd_step_pulse,
    input logic       cmd_motor_on_pulse,
    input logic       cmd_eject_pulse,
    input logic [1:0] drive_motor,
    input logic       active_drive
);
    logic any_cmd;
    assign any_cmd = cmd_dir_pulse | cmd_step_pulse | cmd_motor_on_pulse | cmd_eject_pulse;

    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(switch_state));

    a_r6_onehot_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_dir_pulse, cmd_step_pulse, cmd_motor_on_pulse, cmd_eject_pulse}));

    a_r4_cmd_on_strobe_fall: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |-> ($past(acc_valid) && $past(acc_addr) == 4'h6 && $past(switch_state[3])));

    a_r11_single_motor: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(drive_motor) <= 1) && (drive_motor == 2'b00 || drive_motor[active_drive]));

    a_r7_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr == 4'h9 && !switch_state[4]) |=> drive_motor[active_drive]);

    a_r9_bypass_off: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr == 4'h8 && switch_state[4] && delay_bypass) |=> drive_motor == 2'b00);
endmodule

bind fdc_switch_decoder fdc_switch_decoder_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .acc_valid         (acc_valid),
    .acc_addr          (acc_addr),
    .delay_bypass      (delay_bypass),
    .switch_state      (switch_state),
    .cmd_dir_pulse     (cmd_dir_pulse),
    .cmd_step_pulse    (cmd_step_pulse),
    .cmd_motor_on_pulse(cmd_motor_on_pulse),
    .cmd_eject_pulse   (cmd_eject_pulse),
    .drive_motor       (drive_motor),
    .active_drive      (active_drive)
);

// File: tb/fdc_switch_decoder_tb.sv
module fdc_switch_decoder_tb;
    localparam int HZ = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [3:0] acc_addr = 4'h0;
    logic       side_sel = 1'b0;
    logic       delay_bypass = 1'b0;
    logic [7:0] switch_state;
    logic       cmd_dir_pulse, cmd_dir_value, cmd_step_pulse, cmd_motor_on_pulse, cmd_eject_pulse;
    logic [1:0] drive_motor;
    logic       active_drive;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fdc_switch_decoder #(.CLOCK_HZ(HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .side_sel(side_sel), .delay_bypass(delay_bypass), .switch_state(switch_state),
        .cmd_dir_pulse(cmd_dir_pulse), .cmd_dir_value(cmd_dir_value),
        .cmd_step_pulse(cmd_step_pulse), .cmd_motor_on_pulse(cmd_motor_on_pulse),
        .cmd_eject_pulse(cmd_eject_pulse), .drive_motor(drive_motor),
        .active_drive(active_drive)
    );

    // {addr, expected switch_state}
    localparam logic [11:0] VEC [10] = '{
        {4'h1, 8'h01}, {4'h3, 8'h03}, {4'h5, 8'h07}, {4'h2, 8'h05}, {4'hD, 8'h45},
        {4'hF, 8'hC5}, {4'hC, 8'h85}, {4'h0, 8'h84}, {4'hE, 8'h04}, {4'h4, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the access edge.
    task automatic access(input logic [3:0] a);
        acc_valid = 1'b1;
        acc_addr  = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic [3:0] cmds();
        return {cmd_dir_pulse, cmd_step_pulse, cmd_motor_on_pulse, cmd_eject_pulse};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset switches", switch_state, 8'h00);
        chk("R1 reset motor", drive_motor, 2'b00);
        chk("R1 reset drive", active_drive, 1'b0);
        chk("R1 reset cmds", cmds(), 4'h0);

        // R1 table walk
        for (int i = 0; i < 10; i++) begin
            access(VEC[i][11:8]);
            chk("R1 switch write", switch_state, VEC[i][7:0]);
        end

        // R2 idle cycles with an address present
        acc_addr = 4'h1;
        repeat (3) @(negedge clk);
        chk("R2 idle no change", switch_state, 8'h00);

        // R12 strobe rise, R4 direction command
        access(4'h5);
        access(4'h7);
        chk("R12 strobe rise no cmd", cmds(), 4'h0);
        access(4'h6);
        chk("R4 dir pulse", cmds(), 4'b1000);
        chk("R4 dir value", cmd_dir_value, 1'b1);
        @(negedge clk);
        chk("R6 pulse one cycle", cmds(), 4'h0);
        // R3 strobe cleared again
        access(4'h6);
        chk("R3 redundant strobe clear", cmds(), 4'h0);

        // R5 step
        access(4'h1); access(4'h7); access(4'h6);
        chk("R5 step", cmds(), 4'b0100);
        // R5 motor-on
        access(4'h0); access(4'h3); access(4'h7); access(4'h6);
        chk("R5 motor-on cmd", cmds(), 4'b0010);
        // R5 eject
        access(4'h1); access(4'h7); access(4'h6);
        chk("R5 eject", cmds(), 4'b0001);
        // R5 other code (side set) ignored
        side_sel = 1'b1;
        access(4'h7); access(4'h6);
        chk("R5 other code ignored", cmds(), 4'h0);
        side_sel = 1'b0;
        access(4'h0); access(4'h2);
        chk("R5 phases cleared", switch_state, 8'h04);

        // R7 enable
        access(4'h9);
        chk("R7 motor on drive0", drive_motor, 2'b01);
        // R11 drive moves
        access(4'hB);
        chk("R11 active drive 1", active_drive, 1'b1);
        chk("R11 motor moved to drive1", drive_motor, 2'b10);
        access(4'hA);
        chk("R11 motor back on drive0", drive_motor, 2'b01);

        // R8 delayed off
        access(4'h8);
        repeat (HZ - 1) @(negedge clk);
        chk("R8 still on before delay", drive_motor, 2'b01);
        @(negedge clk);
        chk("R8 off after delay", drive_motor, 2'b00);

        // R10 cancel
        access(4'h9); access(4'h8);
        repeat (5) @(negedge clk);
        access(4'h9);
        repeat (HZ + 10) @(negedge clk);
        chk("R10 cancelled stays on", drive_motor, 2'b01);

        // R3 redundant clear during countdown must not reload it
        access(4'h8);
        repeat (4) @(negedge clk);
        access(4'h8);
        repeat (HZ - 6) @(negedge clk);
        chk("R3 on before original expiry", drive_motor, 2'b01);
        @(negedge clk);
        chk("R3 off at original expiry", drive_motor, 2'b00);

        // R9 bypass
        access(4'h9);
        delay_bypass = 1'b1;
        access(4'h8);
        chk("R9 immediate off", drive_motor, 2'b00);
        delay_bypass = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule